// File: doc/BRIEF.md
# Watchdog Timer Peripheral

This block is a register-mapped watchdog. Software writes a duration, counted in ticks, into a 32-bit down-counter. It then sets the run bit in the control register, and the count starts falling. Each later write of the counter reloads it. That write is the keep-alive action. If software stops writing, the count reaches zero. On that cycle the block latches a sticky expired flag and pulses an interrupt. It can also raise a system reset request, but only while a separate reset-mask bit permits it.

The tick has two sources. The default is the core clock, passed through a power-of-two prescaler whose ratio comes from a control field. A ratio code of 5 gives one tick every 32 clocks. The other source is an external reference tick input, selected by a control bit. The register bus is a plain single-cycle port: address, write data and write strobe, with read data returned combinationally.

Top module: `wdt_periph`

## Requirements
- R1: After reset, every register reads zero, and both irq and reset_out are low.
- R2: A write to offset 0x34 loads the counter with the full 32-bit write data, up to 0xFFFFFFFF. A read of offset 0x34 returns the count that remains.
- R3: While control bit 8 (run) is 0, the count holds its value.
- R4: While run is 1 and control bit 10 is 0, the count falls by one every 2^N clocks, where N is control field [18:16]. The prescaler restarts from zero while run is 0 and on every counter write. So the first decrement lands 2^N clocks after the enabling edge.
- R5: While control bit 10 is 1, the count falls by one on each clock in which ref_tick is high, and the ratio field has no effect.
- R6: The count never goes below zero. On the tick that takes it from 1 to 0, status bit 31 (offset 0x04) is set. In the same cycle that the count first reads 0, irq goes high for exactly one cycle.
- R7: Status bit 31 is sticky. A status write with bit 31 = 0 clears it, and a write with bit 31 = 1 leaves it unchanged. An expiry in the same cycle wins over the clear.
- R8: reset_out is high exactly when an expiry has happened since the last counter write, control bit 8 is 1, and reset-mask bit 8 (offset 0x08) is 1. Clearing either bit drops reset_out at once.
- R9: Reads of unmapped offsets return zero, and writes to them change no register. Control reads back only bits 8, 10 and [18:16]. Reset-mask reads back only bit 8. Status reads back only bit 31.
- R10: A counter write while running restarts the countdown from the new value, and it withdraws any pending reset request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for bus_addr |
| ref_tick | input | 1 | External reference tick, one decrement per high cycle |
| irq | output | 1 | One-cycle expiry pulse |
| reset_out | output | 1 | Gated system reset request |

## Verification
The bench targets the exact cycle of the first decrement after enabling, for ratio codes 0, 2 and 5. A prescaler that fails to restart, or that is off by one, shifts that cycle and the bench catches it. It drives the count through 1 to 0 and then keeps clocking. A design that wraps to 0xFFFFFFFF, pulses irq more than once, or sets the flag a cycle early or late fails there. It toggles the mask and run bits around a held expiry and then reloads the counter. A design that latches the reset request, ignores a gate bit, or misses the keep-alive release shows up in reset_out. Writes to unmapped offsets and all-ones writes to the real registers confirm that nothing stray gets stored.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // register byte offsets
  localparam int OFF_CTRL  = 'h00;
  localparam int OFF_STAT  = 'h04;
  localparam int OFF_RMASK = 'h08;
  localparam int OFF_COUNT = 'h34;

  // field positions
  localparam int CTRL_RUN_BIT   = 8;
  localparam int CTRL_REF_BIT   = 10;
  localparam int CTRL_RATIO_LSB = 16;
  localparam int RATIO_W        = 3;
  localparam int STAT_EXP_BIT   = 31;
  localparam int RMASK_BIT      = 8;

  // prescaler counter spans the largest ratio
  localparam int PCNT_W = (1 << RATIO_W) - 1;

  function automatic logic [PCNT_W-1:0] ratio_mask(input logic [RATIO_W-1:0] r);
    return PCNT_W'((1 << r) - 1);
  endfunction

  // a tick falls on the last clock of each 2^r window
  function automatic logic tick_due(input logic [PCNT_W-1:0] p,
                                    input logic [RATIO_W-1:0] r);
    return (p & ratio_mask(r)) == ratio_mask(r);
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs import wdt_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] cnt_q,
  input  logic              expire_evt,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              run,
  output logic              use_ref,
  output logic [RATIO_W-1:0] ratio,
  output logic              mask_en,
  output logic              stat_exp,
  output logic              stat_clr,
  output logic              cnt_load,
  output logic [DATA_W-1:0] load_val
);
  localparam logic [DATA_W-1:0] CTRL_KEEP =
      (DATA_W'(1) << CTRL_RUN_BIT) | (DATA_W'(1) << CTRL_REF_BIT) |
      (DATA_W'((1 << RATIO_W) - 1) << CTRL_RATIO_LSB);
  localparam logic [DATA_W-1:0] RMASK_KEEP = DATA_W'(1) << RMASK_BIT;

  logic sel_ctrl, sel_stat, sel_rmask, sel_cnt;
  logic [DATA_W-1:0] ctrl_q, rmask_q;
  logic stat_q;

  assign sel_ctrl  = bus_addr == ADDR_W'(OFF_CTRL);
  assign sel_stat  = bus_addr == ADDR_W'(OFF_STAT);
  assign sel_rmask = bus_addr == ADDR_W'(OFF_RMASK);
  assign sel_cnt   = bus_addr == ADDR_W'(OFF_COUNT);

  assign cnt_load = bus_we & sel_cnt;
  assign load_val = bus_wdata;
  assign stat_clr = bus_we & sel_stat & ~bus_wdata[STAT_EXP_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      rmask_q <= '0;
      stat_q  <= 1'b0;
    end else begin
      if (bus_we && sel_ctrl)  ctrl_q  <= bus_wdata & CTRL_KEEP;
      if (bus_we && sel_rmask) rmask_q <= bus_wdata & RMASK_KEEP;
      if (expire_evt)          stat_q  <= 1'b1;
      else if (stat_clr)       stat_q  <= 1'b0;
    end
  end

  assign run      = ctrl_q[CTRL_RUN_BIT];
  assign use_ref  = ctrl_q[CTRL_REF_BIT];
  assign ratio    = ctrl_q[CTRL_RATIO_LSB +: RATIO_W];
  assign mask_en  = rmask_q[RMASK_BIT];
  assign stat_exp = stat_q;

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl)       bus_rdata = ctrl_q;
    else if (sel_stat)  bus_rdata = DATA_W'(stat_q) << STAT_EXP_BIT;
    else if (sel_rmask) bus_rdata = rmask_q;
    else if (sel_cnt)   bus_rdata = cnt_q;
  end
endmodule

// File: rtl/wdt_tickgen.sv
module wdt_tickgen import wdt_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               use_ref,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               restart,
  input  logic               ref_tick,
  output logic               tick
);
  logic [PCNT_W-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pcnt <= '0;
    else if (!run || restart) pcnt <= '0;
    else                     pcnt <= pcnt + PCNT_W'(1);
  end

  assign tick = run & (use_ref ? ref_tick : tick_due(pcnt, ratio));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              tick,
  output logic [DATA_W-1:0] cnt_q,
  output logic              expire_evt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (tick && cnt_q != '0)   cnt_q <= cnt_q - DATA_W'(1);
  end

  assign expire_evt = tick & ~load & (cnt_q == DATA_W'(1));
endmodule

// File: rtl/wdt_periph.sv
module wdt_periph import wdt_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ref_tick,
  output logic              irq,
  output logic              reset_out
);
  logic run, use_ref, mask_en, stat_exp, stat_clr, cnt_load;
  logic tick, expire_evt, irq_q, hold_q;
  logic [RATIO_W-1:0] ratio;
  logic [DATA_W-1:0] load_val, cnt_q;

  wdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .cnt_q(cnt_q), .expire_evt(expire_evt),
    .bus_rdata(bus_rdata), .run(run), .use_ref(use_ref), .ratio(ratio),
    .mask_en(mask_en), .stat_exp(stat_exp), .stat_clr(stat_clr),
    .cnt_load(cnt_load), .load_val(load_val)
  );

  wdt_tickgen u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .use_ref(use_ref), .ratio(ratio),
    .restart(cnt_load), .ref_tick(ref_tick), .tick(tick)
  );

  wdt_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(load_val),
    .tick(tick), .cnt_q(cnt_q), .expire_evt(expire_evt)
  );

  // irq follows the expiry edge; hold remembers it until a reload
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      irq_q <= expire_evt;
      if (cnt_load)        hold_q <= 1'b0;
      else if (expire_evt) hold_q <= 1'b1;
    end
  end

  assign irq       = irq_q;
  assign reset_out = hold_q & run & mask_en;
endmodule

// File: rtl/wdt_periph_chk.sv
module wdt_periph_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              reset_out,
  input logic              run,
  input logic              mask_en,
  input logic              stat_exp,
  input logic              stat_clr,
  input logic              cnt_load,
  input logic [DATA_W-1:0] cnt_q
);
  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R6
  irq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt_q == '0 && stat_exp));
  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !cnt_load) |=> cnt_q == '0);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_load) |=> $stable(cnt_q));
  // R8
  rst_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_out |-> (run && mask_en));
  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_exp && !stat_clr) |=> stat_exp);
  // R10
  reload_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> !reset_out);
endmodule

bind wdt_periph wdt_periph_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .reset_out(reset_out), .run(run),
  .mask_en(mask_en), .stat_exp(stat_exp), .stat_clr(stat_clr),
  .cnt_load(cnt_load), .cnt_q(cnt_q)
);

// File: tb/wdt_periph_test.sv
module wdt_periph_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_RMASK = 8'h08, A_CNT = 8'h34;
  localparam logic [31:0] RUN = 32'h0000_0100, REFSEL = 32'h0000_0400, EXP = 32'h8000_0000;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, ref_tick = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, reset_out;
  int nchecks = 0, nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_periph uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .ref_tick(ref_tick),
    .irq(irq), .reset_out(reset_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a; #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl", A_CTRL, 0);
    rd_chk("R1 stat", A_STAT, 0);
    rd_chk("R1 rmask", A_RMASK, 0);
    rd_chk("R1 count", A_CNT, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 reset_out", {31'b0, reset_out}, 0);
  endtask

  task automatic t_basic_expiry;
    wr(A_CNT, 10);
    wr(A_CTRL, RUN);
    cycles(3);
    rd_chk("R4 ratio0 count", A_CNT, 7);
    cycles(6);
    rd_chk("R6 before zero", A_CNT, 1);
    chk("R6 irq early", {31'b0, irq}, 0);
    rd_chk("R6 stat early", A_STAT, 0);
    cycles(1);
    rd_chk("R6 at zero", A_CNT, 0);
    chk("R6 irq pulse", {31'b0, irq}, 1);
    rd_chk("R6 stat set", A_STAT, EXP);
    chk("R8 masked", {31'b0, reset_out}, 0);
    cycles(1);
    chk("R6 irq one cycle", {31'b0, irq}, 0);
    cycles(4);
    rd_chk("R6 no wrap", A_CNT, 0);
  endtask

  task automatic t_sticky;
    wr(A_STAT, EXP);
    rd_chk("R7 write one keeps", A_STAT, EXP);
    wr(A_STAT, 32'h7FFF_FFFF);
    rd_chk("R7 write zero clears", A_STAT, 0);
  endtask

  task automatic t_hold;
    wr(A_CTRL, 0);
    wr(A_CNT, 32'h55);
    cycles(20);
    rd_chk("R3 hold", A_CNT, 32'h55);
  endtask

  task automatic t_prescale;
    wr(A_CTRL, 0);
    wr(A_CNT, 2);
    wr(A_CTRL, RUN | 32'h0005_0000);
    cycles(31);
    rd_chk("R4 div32 before", A_CNT, 2);
    cycles(1);
    rd_chk("R4 div32 first", A_CNT, 1);
    cycles(31);
    rd_chk("R4 div32 mid", A_CNT, 1);
    cycles(1);
    rd_chk("R4 div32 second", A_CNT, 0);
    chk("R6 irq div32", {31'b0, irq}, 1);
    wr(A_CTRL, 0);
    wr(A_CNT, 5);
    wr(A_CTRL, RUN | 32'h0002_0000);
    cycles(8);
    rd_chk("R4 div4", A_CNT, 3);
  endtask

  task automatic t_reset_out;
    wr(A_CTRL, 0);
    wr(A_STAT, 0);
    wr(A_RMASK, RUN);
    wr(A_CNT, 3);
    wr(A_CTRL, RUN);
    cycles(2);
    chk("R8 before expiry", {31'b0, reset_out}, 0);
    cycles(1);
    chk("R8 asserted", {31'b0, reset_out}, 1);
    cycles(5);
    chk("R8 held", {31'b0, reset_out}, 1);
    wr(A_RMASK, 0);
    chk("R8 mask clear", {31'b0, reset_out}, 0);
    wr(A_RMASK, RUN);
    chk("R8 mask set again", {31'b0, reset_out}, 1);
    wr(A_CTRL, 0);
    chk("R8 run clear", {31'b0, reset_out}, 0);
    wr(A_CTRL, RUN);
    chk("R8 run set again", {31'b0, reset_out}, 1);
    wr(A_CNT, 4);
    chk("R10 reload release", {31'b0, reset_out}, 0);
    rd_chk("R10 reload value", A_CNT, 4);
    cycles(2);
    rd_chk("R10 counting", A_CNT, 2);
    wr(A_CNT, 4);
    rd_chk("R10 keepalive restart", A_CNT, 4);
    cycles(3);
    rd_chk("R10 after restart", A_CNT, 1);
    chk("R10 no reset yet", {31'b0, reset_out}, 0);
    cycles(1);
    chk("R10 expires again", {31'b0, reset_out}, 1);
    chk("R6 irq again", {31'b0, irq}, 1);
  endtask

  task automatic t_ref;
    wr(A_CTRL, 0);
    wr(A_CNT, 6);
    wr(A_CTRL, RUN | REFSEL | 32'h0005_0000);
    cycles(40);
    rd_chk("R5 no ref no tick", A_CNT, 6);
    ref_tick = 1'b1;
    cycles(1);
    ref_tick = 1'b0;
    rd_chk("R5 one ref", A_CNT, 5);
    ref_tick = 1'b1;
    cycles(3);
    ref_tick = 1'b0;
    rd_chk("R5 three refs", A_CNT, 2);
  endtask

  task automatic t_unmapped;
    wr(A_CTRL, 0);
    wr(A_STAT, 0);
    wr(A_RMASK, 0);
    wr(A_CNT, 32'h1234);
    rd_chk("R9 read 0x10", 8'h10, 0);
    rd_chk("R9 read 0x0C", 8'h0C, 0);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h38, 32'hFFFF_FFFF);
    rd_chk("R9 ctrl untouched", A_CTRL, 0);
    rd_chk("R9 rmask untouched", A_RMASK, 0);
    rd_chk("R9 count untouched", A_CNT, 32'h1234);
    rd_chk("R9 stat untouched", A_STAT, 0);
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd_chk("R9 ctrl fields", A_CTRL, 32'h0007_0500);
    wr(A_CTRL, 0);
    wr(A_RMASK, 32'hFFFF_FFFF);
    rd_chk("R9 rmask field", A_RMASK, RUN);
    wr(A_RMASK, 0);
  endtask

  task automatic t_max;
    wr(A_CTRL, 0);
    wr(A_CNT, 32'hFFFF_FFFF);
    rd_chk("R2 max load", A_CNT, 32'hFFFF_FFFF);
    wr(A_CTRL, RUN);
    cycles(1);
    rd_chk("R2 max decrement", A_CNT, 32'hFFFF_FFFE);
    chk("R2 no irq", {31'b0, irq}, 0);
    wr(A_CTRL, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    t_reset();
    t_basic_expiry();
    t_sticky();
    t_hold();
    t_prescale();
    t_reset_out();
    t_ref();
    t_unmapped();
    t_max();
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end
endmodule